// File: doc/BRIEF.md
# Backlight Fade Sequencer

This block owns the 5-bit current code applied to a bank of backlight current sinks. Software writes a target code; when fading is off the applied code follows at once, and when fading is on the applied code walks toward the target one code per fade interval. The fade interval is counted in millisecond ticks and is chosen by a 2-bit rate selector.

A fade in progress can be steered to a new target, can change speed on the fly, and is cancelled by clearing the fade enable. Clearing the enable lands the output directly on the target. Fading only advances while at least one sink is enabled. Codes 1 to 3 carry no current level, so the sequencer never rests on them. A microamp value for the applied code is provided for checking.

Top module: `bl_fade_seq`

## Requirements
- R1: After a synchronous reset, the applied code and the target code are 0, `busy` is 0 and `cur_ua` is 0.
- R2: With `fade_en` low, a code written with `tgt_wr` appears on `cur_code` at the first clock edge that samples the write.
- R3: With `fade_en` high and a nonzero `sink_en`, `cur_code` moves by exactly one legal step toward the target, and only on a cycle with `ms_tick` high. Rate selector 2'b00, 2'b01, 2'b10 and 2'b11 gives 32, 24, 16 and 8 ticks per step.
- R4: Codes 1, 2 and 3 never appear on `cur_code`. When fading, a step up from 0 goes to 4 and a step down from 4 goes to 0.
- R5: A written code of 1, 2 or 3 is stored as code 0.
- R6: A target written during a fade redirects the fade from the present code toward the new target, without restarting the tick count.
- R7: A new rate selector value applies on the next tick. The ticks already counted since the last step are compared against the new interval, so a step happens on the first tick where that count reaches the new interval.
- R8: Clearing `fade_en` sets `cur_code` to the target at the next clock edge.
- R9: While `fade_en` is high and `sink_en` is all zero, `cur_code` holds and the tick count returns to zero.
- R10: `busy` is high exactly when `fade_en` is high and the applied code differs from the stored target. When idle with no write, the code holds.
- R11: `cur_ua` gives the current in microamps: 0 for codes 0 to 3, 500 times (code minus 3) for codes 4 to 13, 5000 plus 1000 per code above 13 for codes 14 to 29, 23000 for code 30 and 25000 for code 31.
- R12: The count of ticks starts from zero whenever the applied code equals the target. The first step of a new fade therefore happens on the interval-th tick after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_wr | input | 1 | One-cycle strobe that writes `tgt_code` as the new target |
| tgt_code | input | 5 | Target current code |
| fade_en | input | 1 | Fading enabled when high |
| rate_sel | input | 2 | Fade interval selector |
| sink_en | input | MASK_W (4) | Sink enable mask; fading advances only when it is nonzero |
| ms_tick | input | 1 | One-cycle millisecond tick |
| cur_code | output | 5 | Applied current code |
| busy | output | 1 | Fade in progress |
| cur_ua | output | 15 | Applied current in microamps |

## Verification
A write or an enable change is sampled at one rising edge, and `cur_code` shows its result after that same edge. `busy` and `cur_ua` follow `cur_code` within the same cycle, with no added register. A fade step is due at the edge that samples the tick completing the interval. The bench keeps a behavioural model that updates on that same edge and compares all three outputs at every falling edge. Stimulus changes just after a rising edge, so every comparison sees settled values.

// File: rtl/bl_fade_pkg.sv
package bl_fade_pkg;

    localparam int CODE_W      = 5;
    localparam int RATE_W      = 2;
    localparam int UA_W        = 15;
    localparam int CODE_MIN_ON = 4;
    localparam int FINE_TOP    = 13;
    localparam int MID_TOP     = 29;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [RATE_W-1:0] rate_t;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;

    typedef struct packed {
        code_t cur;
        code_t tgt;
    } level_s;

    function automatic code_t sanitize(code_t c);
        if (c != '0 && int'(c) < CODE_MIN_ON)
            return '0;
        return c;
    endfunction

    function automatic dir_e dir_of(level_s l);
        if (l.tgt > l.cur)
            return DIR_UP;
        if (l.tgt < l.cur)
            return DIR_DOWN;
        return DIR_HOLD;
    endfunction

    function automatic code_t step_toward(code_t cur, dir_e d);
        case (d)
            DIR_UP:   return (cur == '0) ? code_t'(CODE_MIN_ON) : cur + 1'b1;
            DIR_DOWN: return (int'(cur) == CODE_MIN_ON) ? '0 : cur - 1'b1;
            default:  return cur;
        endcase
    endfunction

    function automatic logic is_adjacent(code_t a, code_t b);
        int x;
        int y;
        x = int'(a);
        y = int'(b);
        if ((x == 0 && y == CODE_MIN_ON) || (y == 0 && x == CODE_MIN_ON))
            return 1'b1;
        return (x - y == 1) || (y - x == 1);
    endfunction

    function automatic int interval_ticks(rate_t sel, int unit);
        return ((1 << RATE_W) - int'(sel)) * unit;
    endfunction

    function automatic logic [UA_W-1:0] code_to_ua(code_t c);
        int k;
        int v;
        k = int'(c);
        if (k < CODE_MIN_ON)
            v = 0;
        else if (k <= FINE_TOP)
            v = 500 * (k - (CODE_MIN_ON - 1));
        else if (k <= MID_TOP)
            v = 5000 + 1000 * (k - FINE_TOP);
        else
            v = 23000 + 2000 * (k - (MID_TOP + 1));
        return UA_W'(v);
    endfunction

endpackage

// File: rtl/bl_fade_target.sv
module bl_fade_target
    import bl_fade_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  code_t wr_code,
    output code_t eff_tgt,
    output code_t tgt_q
);

    always_comb begin
        eff_tgt = wr ? sanitize(wr_code) : tgt_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            tgt_q <= '0;
        else
            tgt_q <= eff_tgt;
    end

    p_stored_legal_r5: assert property (@(posedge clk) disable iff (rst)
        (tgt_q == '0 || int'(tgt_q) >= CODE_MIN_ON));

endmodule

// File: rtl/bl_fade_timer.sv
module bl_fade_timer
    import bl_fade_pkg::*;
#(
    parameter int UNIT_TICKS = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  tick,
    input  rate_t rate_sel,
    output logic  step
);

    localparam int MAX_TICKS = (1 << RATE_W) * UNIT_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W:0]   limit;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        limit   = (CNT_W + 1)'(interval_ticks(rate_sel, UNIT_TICKS));
        step    = run && tick && (cnt_inc >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= step ? '0 : cnt_inc[CNT_W-1:0];
    end

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt_q) < MAX_TICKS));

    p_idle_clear_r12: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(run)) |-> (cnt_q == '0));

endmodule

// File: rtl/bl_fade_stepper.sv
module bl_fade_stepper
    import bl_fade_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fade_en,
    input  logic  step,
    input  code_t eff_tgt,
    output code_t cur_q
);

    level_s lvl;
    dir_e   dir;
    code_t  cur_d;

    always_comb begin
        lvl.cur = cur_q;
        lvl.tgt = eff_tgt;
        dir     = dir_of(lvl);
        if (!fade_en)
            cur_d = eff_tgt;
        else if (step)
            cur_d = step_toward(cur_q, dir);
        else
            cur_d = cur_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= '0;
        else
            cur_q <= cur_d;
    end

    p_one_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fade_en) && cur_q != $past(cur_q))
            |-> is_adjacent($past(cur_q), cur_q));

    p_no_reserved_r4: assert property (@(posedge clk) disable iff (rst)
        (cur_q == '0 || int'(cur_q) >= CODE_MIN_ON));

    p_snap_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(fade_en)) |-> (cur_q == $past(eff_tgt)));

endmodule

// File: rtl/bl_fade_seq.sv
module bl_fade_seq
    import bl_fade_pkg::*;
#(
    parameter int MASK_W     = 4,
    parameter int UNIT_TICKS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tgt_wr,
    input  logic [CODE_W-1:0] tgt_code,
    input  logic              fade_en,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [MASK_W-1:0] sink_en,
    input  logic              ms_tick,
    output logic [CODE_W-1:0] cur_code,
    output logic              busy,
    output logic [UA_W-1:0]   cur_ua
);

    code_t eff_tgt;
    code_t tgt_q;
    code_t cur_q;
    logic  run;
    logic  step;

    bl_fade_target u_target (
        .clk     (clk),
        .rst     (rst),
        .wr      (tgt_wr),
        .wr_code (tgt_code),
        .eff_tgt (eff_tgt),
        .tgt_q   (tgt_q)
    );

    always_comb begin
        run = fade_en && (sink_en != '0) && (cur_q != eff_tgt);
    end

    bl_fade_timer #(
        .UNIT_TICKS (UNIT_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tick     (ms_tick),
        .rate_sel (rate_sel),
        .step     (step)
    );

    bl_fade_stepper u_stepper (
        .clk     (clk),
        .rst     (rst),
        .fade_en (fade_en),
        .step    (step),
        .eff_tgt (eff_tgt),
        .cur_q   (cur_q)
    );

    always_comb begin
        cur_code = cur_q;
        busy     = fade_en && (cur_q != tgt_q);
        cur_ua   = code_to_ua(cur_q);
    end

    p_move_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fade_en) && cur_q != $past(cur_q)) |-> $past(ms_tick));

    p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fade_en) && $past(sink_en) == '0)
            |-> (cur_q == $past(cur_q)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fade_en) && !$past(busy) && !$past(tgt_wr))
            |-> (cur_q == $past(cur_q)));

endmodule

// File: tb/bl_fade_seq_tb_top.sv
module bl_fade_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 2;
    localparam int WATCHDOG   = 150000;

    logic        clk;
    logic        rst;
    logic        tgt_wr;
    logic [4:0]  tgt_code;
    logic        fade_en;
    logic [1:0]  rate_sel;
    logic [3:0]  sink_en;
    logic        ms_tick;
    logic [4:0]  cur_code;
    logic        busy;
    logic [14:0] cur_ua;

    int n_cmp  = 0;
    int n_fail = 0;
    int tdiv   = 0;
    int m_cur  = 0;
    int m_tgt  = 0;
    int m_cnt  = 0;
    string phase = "R1";

    bl_fade_seq dut_i (
        .clk      (clk),
        .rst      (rst),
        .tgt_wr   (tgt_wr),
        .tgt_code (tgt_code),
        .fade_en  (fade_en),
        .rate_sel (rate_sel),
        .sink_en  (sink_en),
        .ms_tick  (ms_tick),
        .cur_code (cur_code),
        .busy     (busy),
        .cur_ua   (cur_ua)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // millisecond tick: one cycle high every TICK_DIV cycles
    initial ms_tick = 1'b0;
    always begin
        @(posedge clk);
        #1;
        if (tdiv == TICK_DIV - 1) begin
            ms_tick = 1'b1;
            tdiv    = 0;
        end else begin
            ms_tick = 1'b0;
            tdiv    = tdiv + 1;
        end
    end

    function automatic int exp_ua(int c);
        if (c < 4)  return 0;
        if (c < 14) return c * 500 - 1500;
        if (c < 30) return (c - 8) * 1000;
        return 25000 - (31 - c) * 2000;
    endfunction

    // behavioural reference: state advanced at each rising edge
    always @(posedge clk) begin : model
        int eff;
        int lim;
        bit run;
        bit adv;
        if (rst) begin
            m_cur = 0;
            m_tgt = 0;
            m_cnt = 0;
        end else begin
            eff = tgt_wr ? int'(tgt_code) : m_tgt;
            if (eff >= 1 && eff <= 3) eff = 0;
            lim = 32 - 8 * int'(rate_sel);
            run = fade_en && (sink_en != 0) && (m_cur != eff);
            adv = run && ms_tick && (m_cnt + 1 >= lim);
            if (!run)          m_cnt = 0;
            else if (ms_tick)  m_cnt = adv ? 0 : m_cnt + 1;
            if (!fade_en)
                m_cur = eff;
            else if (adv) begin
                if (eff > m_cur)      m_cur = (m_cur == 0) ? 4 : m_cur + 1;
                else                  m_cur = (m_cur == 4) ? 0 : m_cur - 1;
            end
            m_tgt = eff;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            n_cmp = n_cmp + 3;
            if (int'(cur_code) != m_cur) begin
                n_fail++;
                $display("FAIL %s cur_code actual=%0d expected=%0d t=%0t", phase, cur_code, m_cur, $time);
            end
            if (busy != (fade_en && m_cur != m_tgt)) begin
                n_fail++;
                $display("FAIL %s/R10 busy actual=%0d expected=%0d t=%0t", phase, busy,
                         (fade_en && m_cur != m_tgt), $time);
            end
            if (int'(cur_ua) != exp_ua(m_cur)) begin
                n_fail++;
                $display("FAIL %s/R11 cur_ua actual=%0d expected=%0d t=%0t", phase, cur_ua,
                         exp_ua(m_cur), $time);
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic write_code(int c);
        @(posedge clk); #1;
        tgt_wr   = 1'b1;
        tgt_code = 5'(c);
        @(posedge clk); #1;
        tgt_wr   = 1'b0;
    endtask

    task automatic cycles(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_idle(int maxc);
        bit done;
        done = 0;
        for (int i = 0; i < maxc && !done; i++) begin
            @(negedge clk);
            if (!busy) done = 1;
        end
        chk({phase, " idle reached"}, int'(done), 1);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int held;
        rst = 1'b1; tgt_wr = 1'b0; tgt_code = '0; fade_en = 1'b0;
        rate_sel = 2'b00; sink_en = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 cur_code", int'(cur_code), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 cur_ua", int'(cur_ua), 0);

        // immediate writes with fading off
        phase = "R2";
        write_code(20);
        @(negedge clk);
        chk("R2 immediate code", int'(cur_code), 20);
        phase = "R5";
        write_code(2);
        @(negedge clk);
        chk("R5 reserved write stored as 0", int'(cur_code), 0);

        // microamp lookup at boundary codes
        phase = "R11";
        write_code(4);  @(negedge clk); chk("R11 code4",  int'(cur_ua), 500);
        write_code(13); @(negedge clk); chk("R11 code13", int'(cur_ua), 5000);
        write_code(14); @(negedge clk); chk("R11 code14", int'(cur_ua), 6000);
        write_code(29); @(negedge clk); chk("R11 code29", int'(cur_ua), 21000);
        write_code(30); @(negedge clk); chk("R11 code30", int'(cur_ua), 23000);
        write_code(31); @(negedge clk); chk("R11 code31", int'(cur_ua), 25000);
        write_code(0);  @(negedge clk); chk("R11 code0",  int'(cur_ua), 0);

        // full upward fade at fastest rate, through the reserved gap
        phase = "R3/R4/R12";
        @(posedge clk); #1;
        sink_en = 4'b0101; fade_en = 1'b1; rate_sel = 2'b11;
        write_code(31);
        @(negedge clk);
        chk("R10 busy during fade", int'(busy), 1);
        wait_idle(4000);
        chk("R3 reached 31", int'(cur_code), 31);

        // downward fade at slowest rate
        phase = "R3/R4 down";
        @(posedge clk); #1 rate_sel = 2'b00;
        write_code(0);
        wait_idle(6000);
        chk("R4 reached 0", int'(cur_code), 0);

        // redirect mid-fade
        phase = "R6";
        @(posedge clk); #1 rate_sel = 2'b10;
        write_code(20);
        cycles(300);
        write_code(8);
        wait_idle(4000);
        chk("R6 redirected target", int'(cur_code), 8);

        // rate change mid-fade with count already past the new interval
        phase = "R7";
        @(posedge clk); #1 rate_sel = 2'b00;
        write_code(31);
        cycles(40);
        @(posedge clk); #1 rate_sel = 2'b11;
        cycles(30);
        @(posedge clk); #1 rate_sel = 2'b01;
        wait_idle(6000);
        chk("R7 reached 31", int'(cur_code), 31);

        // cancel by clearing enable
        phase = "R8";
        write_code(0);
        cycles(200);
        @(posedge clk); #1 fade_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R8 snap to target", int'(cur_code), 0);
        chk("R8 busy clear", int'(busy), 0);

        // sink mask empty freezes fading
        phase = "R9";
        @(posedge clk); #1 fade_en = 1'b1; rate_sel = 2'b11;
        write_code(25);
        cycles(100);
        @(posedge clk); #1 sink_en = 4'b0000;
        @(negedge clk);
        held = int'(cur_code);
        cycles(300);
        @(negedge clk);
        chk("R9 code held with no sinks", int'(cur_code), held);
        chk("R9 busy while frozen", int'(busy), 1);
        @(posedge clk); #1 sink_en = 4'b1000;
        wait_idle(4000);
        chk("R9 resumed to 25", int'(cur_code), 25);
        chk("R10 busy low at target", int'(busy), 0);

        // idle write of same code while enabled: no motion
        phase = "R10";
        write_code(25);
        cycles(100);
        @(negedge clk);
        chk("R10 idle hold", int'(cur_code), 25);

        cycles(5);
        finish_run();
    end

endmodule